// File: doc/BRIEF.md
# Interrupt Message Authorization Filter

This block stands between the devices that raise message-style interrupts and the interrupt controllers of the cores. Each incoming message names the device that sent it, a destination core and a vector. The block checks every message, with no path around the check. It looks up the sender's device ID in a table that software programs. A message is forwarded only when that entry is valid and both its destination core and its vector equal the values the entry authorizes. Any other message is discarded and never reaches the output. The block also keeps a record of the most recent discarded message and raises a sticky fault flag.

Authorized messages leave through a single output register. That register is controlled by a two-state machine. In `OUT_EMPTY` the register holds nothing. In `OUT_FULL` it holds one authorized message. The transitions are:
- `T_LOAD`: `OUT_EMPTY` to `OUT_FULL`, when an authorized message is accepted.
- `T_REFILL`: `OUT_FULL` to `OUT_FULL`, when a message is handed on and a new authorized one is taken in the same cycle.
- `T_HOLD`: `OUT_FULL` to `OUT_FULL`, when the output is stalled.
- `T_DRAIN`: `OUT_FULL` to `OUT_EMPTY`, when a message is handed on and no authorized replacement arrives.

Discarded messages never change the state.

Top module: `irq_msg_filter`

## Requirements
- R1: Every accepted message (in_valid and in_ready high at a rising edge) is checked. Only messages that pass the check ever appear on the output, with device ID, core and vector unchanged.
- R2: The table is indexed by the sender's device ID. If the entry's valid bit is 0, the message is dropped with reason code 1.
- R3: If the entry is valid and the message's core differs from the authorized core, the message is dropped with reason code 2. The core check has priority over the vector check.
- R4: If the entry is valid and the core matches but the vector differs, the message is dropped with reason code 3.
- R5: A message accepted at edge k is presented with out_valid high from edge k onward, which is one cycle of latency. Authorized messages leave in the order they were accepted, and one message per cycle is sustained when out_ready stays high.
- R6: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the output message is held unchanged.
- R7: A dropped message sets fault_flag at the next edge. It also loads fault_dev, fault_core, fault_vec and fault_reason with that message's fields and reason code, overwriting any earlier record. A drop never raises out_valid.
- R8: A fault_clr pulse clears fault_flag at the next edge, unless a drop is accepted in the same cycle, in which case the flag stays set. fault_clr does not alter the record fields.
- R9: A table write (tbl_we) at edge k governs messages accepted from edge k+1 onward. A message accepted at edge k is judged against the old entry.
- R10: After reset, out_valid is 0, fault_flag is 0, fault_reason is 0 and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Filter can accept a message |
| in_dev | input | DEV_W | Sender device ID |
| in_core | input | CORE_W | Requested destination core |
| in_vec | input | VEC_W | Requested vector |
| out_valid | output | 1 | Authorized message valid |
| out_ready | input | 1 | Downstream takes the message |
| out_dev | output | DEV_W | Forwarded device ID |
| out_core | output | CORE_W | Forwarded destination core |
| out_vec | output | VEC_W | Forwarded vector |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_dev | input | DEV_W | Entry index to write |
| tbl_ok | input | 1 | Valid bit to write |
| tbl_core | input | CORE_W | Authorized core to write |
| tbl_vec | input | VEC_W | Authorized vector to write |
| fault_clr | input | 1 | Write-one-to-clear of fault_flag |
| fault_flag | output | 1 | Sticky drop indication |
| fault_reason | output | 2 | 0 none, 1 invalid entry, 2 wrong core, 3 wrong vector |
| fault_dev | output | DEV_W | Device ID of last dropped message |
| fault_core | output | CORE_W | Core of last dropped message |
| fault_vec | output | VEC_W | Vector of last dropped message |

## Verification
The properties assume that in_valid, out_ready and fault_clr are driven low while reset is asserted. The hold property also assumes that the downstream side does not depend on the message being withdrawn. The bench drives every input on the falling edge and keeps all of them low during reset. It holds out_ready low for long stretches so that stalls, refills and drains all occur. It mixes authorized messages with forged ones whose fields differ in exactly one place. Table writes are sometimes aimed at the device that is sending in the same cycle.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_NO_ENTRY = 2'd1,
        RSN_BAD_CORE = 2'd2,
        RSN_BAD_VEC  = 2'd3
    } reason_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } ostate_e;
endpackage

// File: rtl/irqf_table.sv
module irqf_table #(
    parameter int DEV_W  = 4,
    parameter int CORE_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DEV_W-1:0]  wr_dev,
    input  logic              wr_ok,
    input  logic [CORE_W-1:0] wr_core,
    input  logic [VEC_W-1:0]  wr_vec,
    input  logic [DEV_W-1:0]  rd_dev,
    output logic              rd_ok,
    output logic [CORE_W-1:0] rd_core,
    output logic [VEC_W-1:0]  rd_vec
);
    localparam int N_DEV = 1 << DEV_W;

    logic              ok_q   [N_DEV];
    logic [CORE_W-1:0] core_q [N_DEV];
    logic [VEC_W-1:0]  vec_q  [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ok_q[g]   <= 1'b0;
                core_q[g] <= '0;
                vec_q[g]  <= '0;
            end else if (wr_en && (wr_dev == DEV_W'(g))) begin
                ok_q[g]   <= wr_ok;
                core_q[g] <= wr_core;
                vec_q[g]  <= wr_vec;
            end
        end
    end

    // Registered contents only: a write lands after the edge that carries it.
    always_comb begin
        rd_ok   = ok_q[rd_dev];
        rd_core = core_q[rd_dev];
        rd_vec  = vec_q[rd_dev];
    end
endmodule

// File: rtl/irqf_judge.sv
module irqf_judge #(
    parameter int CORE_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              ent_ok,
    input  logic [CORE_W-1:0] ent_core,
    input  logic [VEC_W-1:0]  ent_vec,
    input  logic [CORE_W-1:0] msg_core,
    input  logic [VEC_W-1:0]  msg_vec,
    output logic              pass,
    output irqf_pkg::reason_e reason
);
    import irqf_pkg::*;

    always_comb begin
        if (!ent_ok) begin
            reason = RSN_NO_ENTRY;
        end else if (msg_core != ent_core) begin
            reason = RSN_BAD_CORE;
        end else if (msg_vec != ent_vec) begin
            reason = RSN_BAD_VEC;
        end else begin
            reason = RSN_NONE;
        end
        pass = (reason == RSN_NONE);
    end
endmodule

// File: rtl/irqf_fault_log.sv
module irqf_fault_log #(
    parameter int DEV_W  = 4,
    parameter int CORE_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drop,
    input  irqf_pkg::reason_e drop_reason,
    input  logic [DEV_W-1:0]  drop_dev,
    input  logic [CORE_W-1:0] drop_core,
    input  logic [VEC_W-1:0]  drop_vec,
    input  logic              clr,
    output logic              flag,
    output logic [1:0]        reason,
    output logic [DEV_W-1:0]  dev,
    output logic [CORE_W-1:0] core,
    output logic [VEC_W-1:0]  vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            reason <= 2'd0;
            dev    <= '0;
            core   <= '0;
            vec    <= '0;
        end else if (drop) begin
            flag   <= 1'b1;
            reason <= drop_reason;
            dev    <= drop_dev;
            core   <= drop_core;
            vec    <= drop_vec;
        end else if (clr) begin
            flag   <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_msg_filter.sv
module irq_msg_filter #(
    parameter int DEV_W  = 4,
    parameter int CORE_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DEV_W-1:0]  in_dev,
    input  logic [CORE_W-1:0] in_core,
    input  logic [VEC_W-1:0]  in_vec,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DEV_W-1:0]  out_dev,
    output logic [CORE_W-1:0] out_core,
    output logic [VEC_W-1:0]  out_vec,
    input  logic              tbl_we,
    input  logic [DEV_W-1:0]  tbl_dev,
    input  logic              tbl_ok,
    input  logic [CORE_W-1:0] tbl_core,
    input  logic [VEC_W-1:0]  tbl_vec,
    input  logic              fault_clr,
    output logic              fault_flag,
    output logic [1:0]        fault_reason,
    output logic [DEV_W-1:0]  fault_dev,
    output logic [CORE_W-1:0] fault_core,
    output logic [VEC_W-1:0]  fault_vec
);
    import irqf_pkg::*;

    localparam int MSG_W = DEV_W + CORE_W + VEC_W;

    logic              ent_ok;
    logic [CORE_W-1:0] ent_core;
    logic [VEC_W-1:0]  ent_vec;
    logic              judge_pass;
    reason_e           judge_reason;
    logic              take;
    logic              load;
    logic              drop;
    logic              pop;
    ostate_e           state_q;
    ostate_e           state_d;
    logic [MSG_W-1:0]  msg_q;

    irqf_table #(.DEV_W(DEV_W), .CORE_W(CORE_W), .VEC_W(VEC_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_dev  (tbl_dev),
        .wr_ok   (tbl_ok),
        .wr_core (tbl_core),
        .wr_vec  (tbl_vec),
        .rd_dev  (in_dev),
        .rd_ok   (ent_ok),
        .rd_core (ent_core),
        .rd_vec  (ent_vec)
    );

    irqf_judge #(.CORE_W(CORE_W), .VEC_W(VEC_W)) u_judge (
        .ent_ok   (ent_ok),
        .ent_core (ent_core),
        .ent_vec  (ent_vec),
        .msg_core (in_core),
        .msg_vec  (in_vec),
        .pass     (judge_pass),
        .reason   (judge_reason)
    );

    irqf_fault_log #(.DEV_W(DEV_W), .CORE_W(CORE_W), .VEC_W(VEC_W)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .drop        (drop),
        .drop_reason (judge_reason),
        .drop_dev    (in_dev),
        .drop_core   (in_core),
        .drop_vec    (in_vec),
        .clr         (fault_clr),
        .flag        (fault_flag),
        .reason      (fault_reason),
        .dev         (fault_dev),
        .core        (fault_core),
        .vec         (fault_vec)
    );

    // Handshake decode: every accepted message goes through the judge.
    always_comb begin
        pop      = (state_q == OUT_FULL) && out_ready;
        in_ready = (state_q == OUT_EMPTY) || out_ready;
        take     = in_valid && in_ready;
        load     = take && judge_pass;
        drop     = take && !judge_pass;
    end

    // Next state: T_LOAD, T_REFILL, T_HOLD, T_DRAIN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (load) state_d = OUT_FULL;
            OUT_FULL:  if (pop && !load) state_d = OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output payload register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q <= '0;
        end else if (load) begin
            msg_q <= {in_dev, in_core, in_vec};
        end
    end

    always_comb begin
        out_valid = (state_q == OUT_FULL);
        {out_dev, out_core, out_vec} = msg_q;
    end
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
    parameter int DEV_W  = 4,
    parameter int CORE_W = 3,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DEV_W-1:0]  in_dev,
    input logic [CORE_W-1:0] in_core,
    input logic [VEC_W-1:0]  in_vec,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DEV_W-1:0]  out_dev,
    input logic [CORE_W-1:0] out_core,
    input logic [VEC_W-1:0]  out_vec,
    input logic              fault_clr,
    input logic              fault_flag,
    input logic [1:0]        fault_reason,
    input logic              judge_pass,
    input logic [1:0]        judge_reason
);
    assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dev)
                                       && $stable(out_core) && $stable(out_vec)));

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && judge_pass) |=> (out_valid
            && out_dev == $past(in_dev) && out_core == $past(in_core)
            && out_vec == $past(in_vec)));

    assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !judge_pass) |=> (fault_flag
            && fault_reason == $past(judge_reason)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && !(in_valid && in_ready && !judge_pass)) |=> !fault_flag);

    assert_nofwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !(in_valid && in_ready && judge_pass)) |=> !out_valid);
endmodule

bind irq_msg_filter irqf_checker #(.DEV_W(DEV_W), .CORE_W(CORE_W), .VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_dev       (in_dev),
    .in_core      (in_core),
    .in_vec       (in_vec),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_dev      (out_dev),
    .out_core     (out_core),
    .out_vec      (out_vec),
    .fault_clr    (fault_clr),
    .fault_flag   (fault_flag),
    .fault_reason (fault_reason),
    .judge_pass   (judge_pass),
    .judge_reason (judge_reason)
);

// File: tb/sim_irq_msg_filter.sv
module sim_irq_msg_filter;
    localparam int DEV_W  = 4;
    localparam int CORE_W = 3;
    localparam int VEC_W  = 8;
    localparam int NDEV   = 1 << DEV_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DEV_W-1:0]  in_dev = '0;
    logic [CORE_W-1:0] in_core = '0;
    logic [VEC_W-1:0]  in_vec = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DEV_W-1:0]  out_dev;
    logic [CORE_W-1:0] out_core;
    logic [VEC_W-1:0]  out_vec;
    logic              tbl_we = 1'b0;
    logic [DEV_W-1:0]  tbl_dev = '0;
    logic              tbl_ok = 1'b0;
    logic [CORE_W-1:0] tbl_core = '0;
    logic [VEC_W-1:0]  tbl_vec = '0;
    logic              fault_clr = 1'b0;
    logic              fault_flag;
    logic [1:0]        fault_reason;
    logic [DEV_W-1:0]  fault_dev;
    logic [CORE_W-1:0] fault_core;
    logic [VEC_W-1:0]  fault_vec;

    always #10 clk = ~clk;

    irq_msg_filter #(.DEV_W(DEV_W), .CORE_W(CORE_W), .VEC_W(VEC_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dev(in_dev), .in_core(in_core), .in_vec(in_vec),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_dev(out_dev), .out_core(out_core), .out_vec(out_vec),
        .tbl_we(tbl_we), .tbl_dev(tbl_dev), .tbl_ok(tbl_ok),
        .tbl_core(tbl_core), .tbl_vec(tbl_vec),
        .fault_clr(fault_clr), .fault_flag(fault_flag),
        .fault_reason(fault_reason), .fault_dev(fault_dev),
        .fault_core(fault_core), .fault_vec(fault_vec)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state.
    bit  m_ok   [NDEV];
    int  m_core [NDEV];
    int  m_vec  [NDEV];
    int  q_dev[$];
    int  q_core[$];
    int  q_vec[$];
    bit  m_flag = 0;
    int  m_rsn = 0, m_fdev = 0, m_fcore = 0, m_fvec = 0;
    int  last_rsn = 0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int rnd(input int n);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:16]) % n;
    endfunction

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit v, input int dv, input int cr, input int vc,
                        input bit ordy, input bit we, input int wd, input bit wok,
                        input int wc, input int wv, input bit clr);
        bit exp_rdy, acc, pass, pop;
        int rsn;
        @(negedge clk);
        in_valid = v; in_dev = DEV_W'(dv); in_core = CORE_W'(cr); in_vec = VEC_W'(vc);
        out_ready = ordy; tbl_we = we; tbl_dev = DEV_W'(wd); tbl_ok = wok;
        tbl_core = CORE_W'(wc); tbl_vec = VEC_W'(wv); fault_clr = clr;
        #2;
        exp_rdy = (q_dev.size() == 0) || ordy;
        chk(in_ready == exp_rdy, "R6", "in_ready", int'(in_ready), int'(exp_rdy));
        chk(out_valid == (q_dev.size() != 0), "R5", "out_valid",
            int'(out_valid), int'(q_dev.size() != 0));
        if (q_dev.size() != 0) begin
            chk(int'(out_dev) == q_dev[0] && int'(out_core) == q_core[0]
                && int'(out_vec) == q_vec[0], "R1", "out_vec",
                int'(out_vec), q_vec[0]);
        end
        chk(fault_flag == m_flag, "R7 R8", "fault_flag", int'(fault_flag), int'(m_flag));
        chk(int'(fault_reason) == m_rsn, "R2 R3 R4", "fault_reason",
            int'(fault_reason), m_rsn);
        chk(int'(fault_dev) == m_fdev && int'(fault_core) == m_fcore
            && int'(fault_vec) == m_fvec, "R7", "fault_vec", int'(fault_vec), m_fvec);
        // Model update for the coming edge.
        acc = v && exp_rdy;
        if (!m_ok[dv]) rsn = 1;
        else if (m_core[dv] != cr) rsn = 2;
        else if (m_vec[dv] != vc) rsn = 3;
        else rsn = 0;
        pass = acc && (rsn == 0);
        pop  = (q_dev.size() != 0) && ordy;
        last_rsn = acc ? rsn : -1;
        if (pop) begin
            void'(q_dev.pop_front()); void'(q_core.pop_front()); void'(q_vec.pop_front());
        end
        if (pass) begin
            q_dev.push_back(dv); q_core.push_back(cr); q_vec.push_back(vc);
        end
        if (acc && !pass) begin
            m_flag = 1; m_rsn = rsn; m_fdev = dv; m_fcore = cr; m_fvec = vc;
        end else if (clr) begin
            m_flag = 0;
        end
        if (we) begin
            m_ok[wd] = wok; m_core[wd] = wc; m_vec[wd] = wv;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int d = 0; d < NDEV; d++) begin
            m_ok[d] = 0; m_core[d] = 0; m_vec[d] = 0;
        end
        repeat (3) @(posedge clk);
        #3;
        chk(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
        chk(fault_flag == 1'b0, "R10", "fault_flag in reset", int'(fault_flag), 0);
        chk(fault_reason == 2'd0, "R10", "fault_reason in reset", int'(fault_reason), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R10: all entries invalid after reset -> any message drops with code 1.
        step(1, 9, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        idle(1);
        chk(fault_reason == 2'd1, "R10 R2", "reason for fresh table", int'(fault_reason), 1);
        // Program entry 3 = core 5, vector 0x41.
        step(0, 0, 0, 0, 1, 1, 3, 1, 5, 'h41, 1);
        step(1, 3, 5, 'h41, 1, 0, 0, 0, 0, 0, 0);
        #1;
        chk(out_valid && out_vec == 8'h41, "R5", "forwarded next cycle", int'(out_vec), 'h41);
        step(1, 3, 4, 'h41, 1, 0, 0, 0, 0, 0, 0);   // R3 wrong core
        idle(1);
        chk(fault_reason == 2'd2, "R3", "wrong core code", int'(fault_reason), 2);
        step(1, 3, 4, 'h40, 1, 0, 0, 0, 0, 0, 0);   // R3 priority over vector
        idle(1);
        chk(fault_reason == 2'd2, "R3", "core before vector", int'(fault_reason), 2);
        step(1, 3, 5, 'h40, 1, 0, 0, 0, 0, 0, 0);   // R4 wrong vector
        idle(1);
        chk(fault_reason == 2'd3 && fault_vec == 8'h40, "R4", "wrong vector code",
            int'(fault_reason), 3);
        // R9: same-cycle write uses old (invalid) entry, next cycle passes.
        step(1, 7, 1, 9, 1, 1, 7, 1, 1, 9, 1);
        step(1, 7, 1, 9, 1, 0, 0, 0, 0, 0, 0);
        #1;
        chk(out_valid && out_dev == 4'd7, "R9", "write visible next cycle", int'(out_dev), 7);
        chk(fault_dev == 4'd7 && fault_reason == 2'd1, "R9", "same-cycle judged old",
            int'(fault_reason), 1);
        // R8: clear together with a drop keeps flag; clear alone clears.
        step(1, 2, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        idle(1);
        chk(fault_flag == 1'b1, "R8", "drop beats clear", int'(fault_flag), 1);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        idle(1);
        chk(fault_flag == 1'b0 && fault_dev == 4'd2, "R8", "clear alone",
            int'(fault_flag), 0);
        // R6/R5: stall with back-to-back traffic, then release.
        step(1, 3, 5, 'h41, 0, 0, 0, 0, 0, 0, 0);
        step(1, 7, 1, 9, 0, 0, 0, 0, 0, 0, 0);
        step(1, 7, 1, 9, 0, 0, 0, 0, 0, 0, 0);
        step(1, 7, 1, 9, 1, 0, 0, 0, 0, 0, 0);
        step(1, 3, 5, 'h41, 1, 0, 0, 0, 0, 0, 0);
        idle(2);
        // Mixed traffic.
        for (int i = 0; i < 4000; i++) begin
            int d, c, x;
            bit we;
            d = rnd(NDEV);
            c = m_core[d]; x = m_vec[d];
            case (rnd(6))
                0: c = rnd(1 << CORE_W);
                1: x = rnd(1 << VEC_W);
                default: ;
            endcase
            we = (rnd(8) == 0);
            step(rnd(4) != 0, d, c, x, rnd(3) != 0, we,
                 (rnd(2) == 0) ? d : rnd(NDEV), rnd(5) != 0,
                 rnd(1 << CORE_W), rnd(1 << VEC_W), rnd(10) == 0);
        end
        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule